// File: doc/BRIEF.md
# Sub-Addressed I2C Memory Target

This block is an I2C target that lets a host reach a small byte-addressed store. It recovers start and stop conditions and bit timing by sampling the bus lines on the system clock. It acknowledges its own 7-bit address and treats the first two bytes of a write-direction transfer as a 16-bit pointer. Two windows are backed by storage: a 1 KiB data area at 0x8000 and a 9-byte settings area at 0x9000. Every other location reads as 0xFF and ignores writes.

Reads stream bytes from the pointer onward, and the pointer steps by one after each byte. A repeated start after the pointer bytes turns the transfer into a read while keeping the pointer. Written data does not reach storage at once. It is collected in a 64-byte page stage and copied out one byte per clock after the stop condition. A page update must start at offset 0 of its page. Bytes beyond the 64th wrap back into the same page.

The bus is open-drain. The block reports through `sdaOe` when it pulls SDA low and never drives SDA high.

Top module: `i2cSubaddrTarget`

## Requirements
- R1: The first byte after a start is compared with the 7-bit address parameter (bits 7..1; bit 0 set means read). On a match SDA is pulled low for the ninth clock. On a mismatch SDA stays released until the next start or stop.
- R2: In a write-direction transfer the first byte after the address is the high byte of the pointer and the second is the low byte. Every byte the host sends after a matching address is acknowledged.
- R3: A read sends bytes most significant bit first, starting at the pointer, and the pointer steps by one per byte sent. A host ACK (SDA low on the ninth clock) asks for another byte. A NACK ends the stream and leaves SDA released. The block changes SDA only while SCL is low.
- R4: A repeated start followed by a read address keeps the latched pointer. A read transfer that carries no new pointer continues from where the last access left it.
- R5: Locations 0x8000..0x83FF and 0x9000..0x9008 hold what is written to them. The nine settings bytes read 0x00 after reset.
- R6: A read of any location outside both windows returns 0xFF. This includes stepping off the end of a window.
- R7: A write to a location outside both windows is acknowledged but changes nothing. This includes 0x9009..0x903F in the settings page.
- R8: Written bytes are staged and stay invisible until the stop condition ends the transfer. A read inside the same transfer returns the old contents. After the stop the staged page is copied within 64 clocks.
- R9: If the first data byte of a transfer falls at a page offset other than 0 (pointer bits 5..0 not zero), all data bytes of that transfer are discarded.
- R10: Data bytes past the 64th of a page write wrap to offset 0 of the same page, where later bytes overwrite earlier ones. The next page is not touched.
- R11: During and right after reset the block does not pull SDA low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| sdaOe | output | 1 | High when the block pulls SDA low |

## Verification
The hardest state to reach is a staged page that has not yet been copied while a read is under way. The bench gets there in one transfer: a data byte is written, then a repeated start re-sends the pointer, and a second repeated start reads the same location before any stop. It also pushes 65 bytes into one page so that the wrap overwrites offset 0 while a pre-loaded neighbouring page must stay intact. A behavioural memory model keyed by address predicts every byte, including the 0xFF returned past a window's end.

// File: rtl/i2cSubaddrPkg.sv
`timescale 1ns/1ps
package i2cSubaddrPkg;

  // strobes from the bus control to the datapath
  typedef struct packed {
    logic startTxn;    // start or repeated start seen
    logic endTxn;      // stop seen
    logic shiftIn;     // sample one bit into the receive shifter
    logic inBit;       // value of the sampled bit
    logic rxByteDone;  // a written byte (pointer or data) is complete
    logic loadTx;      // fetch next read byte and step the pointer
    logic shiftTx;     // advance the transmit shifter
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WACK,
    ST_RX,
    ST_TX,
    ST_TACK,
    ST_IGNORE
  } busState_t;

endpackage

// File: rtl/i2cSubaddrCtrl.sv
`timescale 1ns/1ps
module i2cSubaddrCtrl
  import i2cSubaddrPkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h50,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic [7:0]   rxByte,
  input  logic         rdMsb,
  input  logic         nextTxBit,
  output ctrlStrobes_t strb,
  output logic         sdaLow
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startDet, stopDet;

  busState_t state, stateN;
  logic [3:0] bitCnt, bitCntN;
  logic isRead, isReadN, hostAck, hostAckN, sdaLowN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  always_comb begin
    stateN     = state;
    bitCntN    = bitCnt;
    isReadN    = isRead;
    hostAckN   = hostAck;
    sdaLowN    = sdaLow;
    strb       = '0;
    strb.inBit = sdaS;
    if (stopDet) begin
      stateN      = ST_IDLE;
      sdaLowN     = 1'b0;
      strb.endTxn = 1'b1;
    end else if (startDet) begin
      stateN        = ST_ADDR;
      bitCntN       = 4'd0;
      sdaLowN       = 1'b0;
      strb.startTxn = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            strb.shiftIn = 1'b1;
            bitCntN      = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == TARGET_ADDR) begin
                isReadN = rxByte[0];
                sdaLowN = 1'b1;
                stateN  = ST_WACK;
              end else begin
                stateN = ST_IGNORE;
              end
            end else begin
              strb.rxByteDone = 1'b1;
              sdaLowN         = 1'b1;
              stateN          = ST_WACK;
            end
          end
        end
        ST_WACK: begin
          if (sclFall) begin
            bitCntN = 4'd0;
            if (isRead) begin
              strb.loadTx = 1'b1;
              sdaLowN     = ~rdMsb;
              stateN      = ST_TX;
            end else begin
              sdaLowN = 1'b0;
              stateN  = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            strb.shiftTx = 1'b1;
            bitCntN      = bitCnt + 4'd1;
            if (bitCnt == 4'd7) begin
              sdaLowN = 1'b0;
              stateN  = ST_TACK;
            end else begin
              sdaLowN = ~nextTxBit;
            end
          end
        end
        ST_TACK: begin
          if (sclRise) begin
            hostAckN = ~sdaS;
          end else if (sclFall) begin
            if (hostAck) begin
              strb.loadTx = 1'b1;
              sdaLowN     = ~rdMsb;
              bitCntN     = 4'd0;
              stateN      = ST_TX;
            end else begin
              stateN = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= 4'd0;
      isRead  <= 1'b0;
      hostAck <= 1'b0;
      sdaLow  <= 1'b0;
    end else begin
      state   <= stateN;
      bitCnt  <= bitCntN;
      isRead  <= isReadN;
      hostAck <= hostAckN;
      sdaLow  <= sdaLowN;
    end
  end

  // the block only moves SDA while the sampled clock line is low (R3)
  assert_sda_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaLow) |-> !sclS);

  // an unaddressed or finished transfer leaves the line alone (R1)
  assert_ignore_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !sdaLow);

  // after a stop the line is released (R3)
  assert_release_after_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaLow);

endmodule

// File: rtl/i2cSubaddrData.sv
`timescale 1ns/1ps
module i2cSubaddrData
  import i2cSubaddrPkg::*;
#(
  parameter int unsigned DATA_BASE  = 32'h8000,
  parameter int unsigned DATA_BYTES = 1024,
  parameter int unsigned CFG_BASE   = 32'h9000,
  parameter int unsigned CFG_BYTES  = 9,
  parameter int unsigned PAGE_BYTES = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  output logic [7:0]   rxByte,
  output logic         rdMsb,
  output logic         nextTxBit
);

  localparam int PAGE_AW = $clog2(PAGE_BYTES);
  localparam int DATA_AW = $clog2(DATA_BYTES);
  localparam int CFG_AW  = $clog2(CFG_BYTES);
  localparam logic [PAGE_AW-1:0] LAST_IDX = PAGE_AW'(PAGE_BYTES - 1);

  function automatic logic inWin(logic [15:0] a, int unsigned base, int unsigned size);
    return (32'(a) >= base) && (32'(a) < base + size);
  endfunction

  logic [7:0]  rxShift;
  logic [6:0]  txShift;
  logic [15:0] subAddr;
  logic [1:0]  byteIdx;
  logic        gotData, pageOk;
  logic [15:0] pageBase, commitBase;
  logic [PAGE_BYTES-1:0] stageMask;
  logic [7:0]  stageBuf [PAGE_BYTES];
  logic        commitBusy;
  logic [PAGE_AW-1:0] commitIdx;
  logic [7:0]  dataMem [DATA_BYTES];
  logic [7:0]  cfgMem  [CFG_BYTES];

  logic        dataWr, commitWr;
  logic [PAGE_AW-1:0] stageOff;
  logic [15:0] tgt;
  logic [7:0]  rdByte;

  assign rxByte    = rxShift;
  assign dataWr    = strb.rxByteDone && (byteIdx == 2'd2);
  assign stageOff  = subAddr[PAGE_AW-1:0];
  assign tgt       = commitBase + 16'(commitIdx);
  assign commitWr  = commitBusy && stageMask[commitIdx];
  assign rdMsb     = rdByte[7];
  assign nextTxBit = txShift[6];

  always_comb begin
    if (inWin(subAddr, DATA_BASE, DATA_BYTES))
      rdByte = dataMem[DATA_AW'(subAddr - 16'(DATA_BASE))];
    else if (inWin(subAddr, CFG_BASE, CFG_BYTES))
      rdByte = cfgMem[CFG_AW'(subAddr - 16'(CFG_BASE))];
    else
      rdByte = 8'hFF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift    <= '0;
      txShift    <= '0;
      subAddr    <= '0;
      byteIdx    <= '0;
      gotData    <= 1'b0;
      pageOk     <= 1'b0;
      pageBase   <= '0;
      commitBase <= '0;
      stageMask  <= '0;
      commitBusy <= 1'b0;
      commitIdx  <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[6:0], strb.inBit};
      if (strb.loadTx) begin
        txShift <= rdByte[6:0];
        subAddr <= subAddr + 16'd1;
      end else if (strb.shiftTx) begin
        txShift <= {txShift[5:0], 1'b0};
      end
      if (strb.startTxn) byteIdx <= 2'd0;
      if (strb.rxByteDone) begin
        case (byteIdx)
          2'd0: begin subAddr[15:8] <= rxShift; byteIdx <= 2'd1; end
          2'd1: begin subAddr[7:0]  <= rxShift; byteIdx <= 2'd2; end
          default: begin
            if (!gotData) begin
              gotData   <= 1'b1;
              pageBase  <= {subAddr[15:PAGE_AW], {PAGE_AW{1'b0}}};
              pageOk    <= (stageOff == '0);
              stageMask <= PAGE_BYTES'(1) << stageOff;
            end else begin
              stageMask[stageOff] <= 1'b1;
            end
            subAddr <= subAddr + 16'd1;
          end
        endcase
      end
      if (commitBusy) begin
        commitIdx <= commitIdx + 1'b1;
        if (commitIdx == LAST_IDX) commitBusy <= 1'b0;
      end
      if (strb.endTxn) begin
        gotData <= 1'b0;
        if (gotData && pageOk) begin
          commitBusy <= 1'b1;
          commitIdx  <= '0;
          commitBase <= pageBase;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dataWr) stageBuf[stageOff] <= rxShift;
  end

  always_ff @(posedge clk) begin
    if (commitWr && inWin(tgt, DATA_BASE, DATA_BYTES))
      dataMem[DATA_AW'(tgt - 16'(DATA_BASE))] <= stageBuf[commitIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CFG_BYTES; i++) cfgMem[i] <= 8'h00;
    end else if (commitWr && inWin(tgt, CFG_BASE, CFG_BYTES)) begin
      cfgMem[CFG_AW'(tgt - 16'(CFG_BASE))] <= stageBuf[commitIdx];
    end
  end

  // the page copy finishes after one pass over the page (R8)
  assert_commit_length_R8: assert property (@(posedge clk) disable iff (!rstN)
    (commitBusy && commitIdx == LAST_IDX) |=> !commitBusy);

  // no new data byte is staged while a copy is running (R8)
  assert_no_stage_in_copy_R8: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |-> !commitBusy);

  // each byte sent steps the pointer by one (R3)
  assert_read_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |=> subAddr == $past(subAddr) + 16'd1);

  // a misaligned first data byte marks the page as not to be copied (R9)
  assert_misaligned_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !gotData && stageOff != '0) |=> !pageOk);

endmodule

// File: rtl/i2cSubaddrTarget.sv
`timescale 1ns/1ps
module i2cSubaddrTarget
  import i2cSubaddrPkg::*;
#(
  parameter logic [6:0]  TARGET_ADDR = 7'h50,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned DATA_BASE   = 32'h8000,
  parameter int unsigned DATA_BYTES  = 1024,
  parameter int unsigned CFG_BASE    = 32'h9000,
  parameter int unsigned CFG_BYTES   = 9,
  parameter int unsigned PAGE_BYTES  = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  ctrlStrobes_t strb;
  logic [7:0]   rxByte;
  logic         rdMsb, nextTxBit, sdaLow;

  i2cSubaddrCtrl #(
    .TARGET_ADDR(TARGET_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .rdMsb(rdMsb), .nextTxBit(nextTxBit),
    .strb(strb), .sdaLow(sdaLow)
  );

  i2cSubaddrData #(
    .DATA_BASE(DATA_BASE), .DATA_BYTES(DATA_BYTES),
    .CFG_BASE(CFG_BASE), .CFG_BYTES(CFG_BYTES),
    .PAGE_BYTES(PAGE_BYTES)
  ) i_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxByte(rxByte), .rdMsb(rdMsb), .nextTxBit(nextTxBit)
  );

  assign sdaOe = sdaLow;

endmodule

// File: tb/test_i2cSubaddrTarget.sv
`timescale 1ns/1ps
module test_i2cSubaddrTarget;

  localparam int Q = 5;
  localparam logic [6:0] TA = 7'h50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostScl = 1'b1;
  logic hostSda = 1'b1;
  logic sdaOe;
  logic sdaLine;

  assign sdaLine = hostSda & ~sdaOe;

  always #2.5 clk = ~clk;

  i2cSubaddrTarget i_i2cSubaddrTarget (
    .clk(clk), .rstN(rstN), .sclIn(hostScl), .sdaIn(sdaLine), .sdaOe(sdaOe)
  );

  int compared = 0;
  int mismatched = 0;
  bit hostDriving = 1'b0;
  bit finished = 1'b0;
  logic [7:0] model [int];
  logic [7:0] wq [$];
  int curAddr = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock model: while the host owns SDA the target must not pull it
  always @(negedge clk) begin
    if (rstN && hostDriving) begin
      compared++;
      if (sdaOe !== 1'b0) begin
        mismatched++;
        $display("FAIL R2 target pulled SDA during host bit actual %b expected 0", sdaOe);
      end
    end
  end

  function automatic bit inData(int a);
    return a >= 'h8000 && a < 'h8400;
  endfunction
  function automatic bit inCfg(int a);
    return a >= 'h9000 && a < 'h9009;
  endfunction
  function automatic logic [7:0] expRead(int a);
    int m = a & 'hFFFF;
    if (inData(m) || inCfg(m)) return model.exists(m) ? model[m] : 8'h00;
    return 8'hFF;
  endfunction

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    hostSda = 1'b1; waitQ();
    hostScl = 1'b1; waitQ();
    hostSda = 1'b0; waitQ();
    hostScl = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    hostSda = 1'b0; waitQ();
    hostScl = 1'b1; waitQ();
    hostSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic writeBit(input logic b);
    hostDriving = 1'b1;
    hostSda = b; waitQ();
    hostScl = 1'b1; waitQ(); waitQ();
    hostScl = 1'b0; hostDriving = 1'b0; waitQ();
  endtask

  task automatic readBit(output logic b);
    hostSda = 1'b1; waitQ();
    hostScl = 1'b1; waitQ();
    b = sdaLine; waitQ();
    hostScl = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(input logic last, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    writeBit(last);
  endtask

  task automatic sendPtr(input int addr, input string tag);
    logic ack;
    sendByte({TA, 1'b0}, ack); chk({tag, " R1 address ack"}, ack, 1);
    sendByte(addr[15:8], ack); chk({tag, " R2 pointer high ack"}, ack, 1);
    sendByte(addr[7:0], ack);  chk({tag, " R2 pointer low ack"}, ack, 1);
  endtask

  // write transfer with the bytes in wq; model applies page and window rules
  task automatic writeTxn(input int addr, input string tag);
    logic ack;
    int base, off;
    startCond();
    sendPtr(addr, tag);
    foreach (wq[i]) begin
      sendByte(wq[i], ack);
      chk({tag, " R2 R7 data ack"}, ack, 1);
    end
    stopCond();
    repeat (80) @(negedge clk);
    if ((addr & 'h3F) == 0) begin
      base = addr & 'hFFC0;
      foreach (wq[i]) begin
        off = (i % 64);
        if (inData(base + off) || inCfg(base + off)) model[base + off] = wq[i];
      end
    end
    curAddr = (addr + wq.size()) & 'hFFFF;
  endtask

  task automatic readBody(input int n, input string tag);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      recvByte(i == n - 1, v);
      chk(tag, v, expRead(curAddr + i));
    end
    curAddr = (curAddr + n) & 'hFFFF;
  endtask

  task automatic readTxn(input int addr, input int n, input string tag);
    logic ack;
    startCond();
    sendPtr(addr, tag);
    startCond();
    sendByte({TA, 1'b1}, ack); chk({tag, " R4 read address ack"}, ack, 1);
    curAddr = addr;
    readBody(n, tag);
    stopCond();
    chk({tag, " R3 SDA released after NACK"}, sdaOe, 0);
    repeat (10) @(negedge clk);
  endtask

  task automatic curReadTxn(input int n, input string tag);
    logic ack;
    startCond();
    sendByte({TA, 1'b1}, ack); chk({tag, " R4 read address ack"}, ack, 1);
    readBody(n, tag);
    stopCond();
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog run did not complete actual timeout expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] v;
    for (int a = 'h9000; a < 'h9009; a++) model[a] = 8'h00;
    repeat (4) @(negedge clk);
    chk("R11 SDA released in reset", sdaOe, 0);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11 SDA released after reset", sdaOe, 0);

    // settings area reads zero, then 0xFF one past its end
    readTxn('h9000, 10, "R5 R6 settings reset and end");

    // plain page write and read back
    wq = {8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7};
    writeTxn('h8000, "R5 data write");
    readTxn('h8000, 8, "R3 R5 data readback");

    wq = {};
    for (int i = 0; i < 16; i++) wq.push_back(8'(8'h30 + i * 7));
    writeTxn('h8040, "R5 second page");
    readTxn('h8040, 16, "R3 second page readback");

    // misaligned first data byte: whole write dropped
    wq = {8'h55, 8'h66};
    writeTxn('h8003, "R9 misaligned");
    readTxn('h8002, 3, "R9 misaligned data discarded");

    // outside both windows: acked, dropped, reads 0xFF
    wq = {8'h12, 8'h34};
    writeTxn('h4000, "R7 outside write");
    readTxn('h4000, 2, "R6 R7 outside reads FF");

    // settings page with bytes past the ninth
    wq = {};
    for (int i = 0; i < 12; i++) wq.push_back(8'(8'hC0 + i));
    writeTxn('h9000, "R5 R7 settings write");
    readTxn('h9000, 12, "R5 R6 R7 settings readback");

    // neighbour page, then a 65-byte write that wraps in the page below
    wq = {};
    for (int i = 0; i < 64; i++) wq.push_back(8'(8'h80 ^ i));
    writeTxn('h83C0, "R5 last page");
    readTxn('h83FE, 3, "R6 step off data end");
    wq = {};
    for (int i = 0; i < 65; i++) wq.push_back(8'(i + 1));
    writeTxn('h8380, "R10 wrap write");
    readTxn('h8380, 2, "R10 offset 0 overwritten by 65th byte");
    readTxn('h83BE, 4, "R10 next page untouched");

    // staged data invisible before stop
    startCond();
    sendPtr('h8000, "R8 stage");
    sendByte(8'h5A, ack); chk("R8 stage data ack", ack, 1);
    startCond();
    sendPtr('h8000, "R8 stage repoint");
    startCond();
    sendByte({TA, 1'b1}, ack); chk("R4 R8 read address ack", ack, 1);
    recvByte(1'b1, v);
    chk("R8 old data before stop", v, 8'hA0);
    stopCond();
    repeat (80) @(negedge clk);
    model['h8000] = 8'h5A;
    readTxn('h8000, 1, "R8 data copied after stop");

    // foreign address: no ack, bus left alone
    startCond();
    sendByte({7'h23, 1'b0}, ack); chk("R1 foreign address not acked", ack, 0);
    sendByte(8'h90, ack); chk("R1 ignored byte not acked", ack, 0);
    stopCond();
    chk("R1 SDA released after foreign transfer", sdaOe, 0);
    readTxn('h8001, 2, "R1 normal after foreign");

    // read continues from the left pointer
    readTxn('h8040, 2, "R4 pointer set");
    curReadTxn(3, "R4 continue without pointer");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule